// File: doc/BRIEF.md
# Periodic L1 Cache Flush Controller

This block bounds how long live contents may sit in a small first-level cache, where they are exposed to particle-induced bit flips. A programmable cycle timer fires a flush at a fixed interval. Shorter intervals cut exposure but cost more refills; typical settings are ten thousand, one hundred thousand or one million cycles.

The block keeps the per-line valid and dirty status bits itself and updates them from the CPU's fill and store events. A parameter chooses one of two flush paths. For a read-only instruction cache, a trigger clears every valid bit in the same clock edge. For a write-back data cache, a sequencer visits the lines in ascending order. Each valid dirty line is sent whole to the next cache level over a request/acknowledge port and then invalidated. A valid clean line is invalidated in one cycle with no transfer, and an invalid line is skipped in one cycle. While the walk runs, `busy` is high and the CPU's status updates are refused.

Top module: `l1_flush_ctrl`

## Requirements
- R1: When `flush_en` is high and `period` is P > 0, a flush is triggered on the P-th rising edge after enabling and then every P edges, because the counter reloads on each trigger. When `flush_en` is low the counter is held at zero. P = 0 never triggers.
- R2: In the instruction-cache variant (`ICACHE`=1), a trigger clears all of `valid_bits` on the trigger edge itself. `busy` and `wb_req` stay low.
- R3: In the data-cache variant, `busy` rises on the trigger edge and falls when the last line has been handled. At that point `valid_bits` and `dirty_bits` are all zero. After reset, the status bits, `busy` and `wb_req` are zero.
- R4: Each line that is valid and dirty when the walk reaches it produces exactly one writeback. That writeback carries the line's index on `wb_idx` and the full line read through `line_idx`/`line_data` on `wb_data`. No request is made for clean or invalid lines, or while `busy` is low. The line is invalidated on the acknowledge edge.
- R5: Once `wb_req` is high, `wb_req`, `wb_idx` and `wb_data` stay unchanged until the cycle in which `wb_ack` is sampled high.
- R6: A clean or invalid line takes one cycle, so a walk over a cache with no dirty lines keeps `busy` high for exactly NUM_LINES cycles.
- R7: A trigger arriving while a walk runs is held. After that walk ends, `busy` is low for exactly one cycle and the next walk then starts.
- R8: `fill_vld` and `store_vld` have no effect while `busy` is high.
- R9: Bit i of `valid_bits`/`dirty_bits` belongs to line i. A fill sets the line valid and clean. A store sets the dirty bit only if the line is already valid; a store to an invalid line is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_en | input | 1 | Enables the flush timer |
| period | input | PERIOD_W | Cycles between flushes; 0 disables triggers |
| fill_vld | input | 1 | CPU line fill event |
| fill_idx | input | IDX_W | Line index of the fill |
| store_vld | input | 1 | CPU store event |
| store_idx | input | IDX_W | Line index of the store |
| line_idx | output | IDX_W | Line the walk is reading from the data array |
| line_data | input | LINE_BITS | Whole line contents at `line_idx` |
| wb_req | output | 1 | Writeback request to the next level |
| wb_idx | output | IDX_W | Index of the line being written back |
| wb_data | output | LINE_BITS | Line contents being written back |
| wb_ack | input | 1 | Next level accepts the writeback |
| busy | output | 1 | Walk in progress; CPU must stall |
| valid_bits | output | NUM_LINES | Per-line valid status |
| dirty_bits | output | NUM_LINES | Per-line dirty status |

## Verification
A trigger lands on the P-th edge after enabling. Its effect, cleared valid bits or a raised `busy`, is visible at the next falling edge, so the bench counts falling edges between enabling and the first `busy` sample and expects exactly P. A fill or store takes effect on the next rising edge and is read back one falling edge later. A writeback request appears one edge after the walk reaches a dirty line and drops one edge after the acknowledge. The bench's acknowledge responder therefore drives `wb_ack` at a falling edge, records index and data there, and releases it on the following falling edge. The held-trigger gap is checked as one falling-edge sample with `busy` low, followed at once by one with it high.

// File: rtl/l1fc_pkg.sv
package l1fc_pkg;
    parameter int unsigned DEF_LINES     = 16;
    parameter int unsigned DEF_LINE_BITS = 256;
    parameter int unsigned DEF_PERIOD_W  = 24;

    typedef enum logic [1:0] {
        WALK_IDLE = 2'd0,
        WALK_SCAN = 2'd1,
        WALK_WAIT = 2'd2
    } walk_state_e;
endpackage

// File: rtl/l1fc_timer.sv
module l1fc_timer #(
    parameter int unsigned PERIOD_W = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic [PERIOD_W-1:0] period,
    output logic                trig
);
    logic [PERIOD_W-1:0] cnt;

    // Fires on the P-th enabled edge; compare with >= so a shortened period takes effect at once.
    assign trig = en && (period != '0) && (cnt >= period - PERIOD_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (trig) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + PERIOD_W'(1);
        end
    end
endmodule

// File: rtl/l1fc_status.sv
module l1fc_status #(
    parameter int unsigned NUM_LINES = 16,
    localparam int unsigned IDX_W = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cpu_ok,
    input  logic                 fill_vld,
    input  logic [IDX_W-1:0]     fill_idx,
    input  logic                 store_vld,
    input  logic [IDX_W-1:0]     store_idx,
    input  logic                 clr_all,
    input  logic                 clr_one,
    input  logic [IDX_W-1:0]     clr_idx,
    output logic [NUM_LINES-1:0] valid,
    output logic [NUM_LINES-1:0] dirty
);
    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            valid <= '0;
            dirty <= '0;
        end else begin
            if (cpu_ok && fill_vld) begin
                valid[fill_idx] <= 1'b1;
                dirty[fill_idx] <= 1'b0;
            end
            if (cpu_ok && store_vld && valid[store_idx]) begin
                dirty[store_idx] <= 1'b1;
            end
            if (clr_one) begin
                valid[clr_idx] <= 1'b0;
                dirty[clr_idx] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/l1fc_walker.sv
module l1fc_walker
    import l1fc_pkg::*;
#(
    parameter int unsigned NUM_LINES = 16,
    parameter int unsigned LINE_BITS = 256,
    localparam int unsigned IDX_W = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 trig,
    input  logic [NUM_LINES-1:0] valid,
    input  logic [NUM_LINES-1:0] dirty,
    input  logic [LINE_BITS-1:0] line_data,
    input  logic                 wb_ack,
    output logic [IDX_W-1:0]     idx,
    output logic                 busy,
    output logic                 wb_req,
    output logic [IDX_W-1:0]     wb_idx,
    output logic [LINE_BITS-1:0] wb_data,
    output logic                 clr_one
);
    walk_state_e state;
    logic        pend;
    logic        last;

    assign last    = (idx == IDX_W'(NUM_LINES - 1));
    assign busy    = (state != WALK_IDLE);
    assign clr_one = ((state == WALK_SCAN) && valid[idx] && !dirty[idx]) ||
                     ((state == WALK_WAIT) && wb_ack);

    // A trigger seen mid-walk is remembered and served from idle.
    always_ff @(posedge clk) begin
        if (rst || state == WALK_IDLE) begin
            pend <= 1'b0;
        end else if (trig) begin
            pend <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= WALK_IDLE;
            idx     <= '0;
            wb_req  <= 1'b0;
            wb_idx  <= '0;
            wb_data <= '0;
        end else begin
            case (state)
                WALK_IDLE: begin
                    if (trig || pend) begin
                        state <= WALK_SCAN;
                        idx   <= '0;
                    end
                end
                WALK_SCAN: begin
                    if (valid[idx] && dirty[idx]) begin
                        wb_req  <= 1'b1;
                        wb_idx  <= idx;
                        wb_data <= line_data;
                        state   <= WALK_WAIT;
                    end else if (last) begin
                        state <= WALK_IDLE;
                    end else begin
                        idx <= idx + IDX_W'(1);
                    end
                end
                WALK_WAIT: begin
                    if (wb_ack) begin
                        wb_req <= 1'b0;
                        if (last) begin
                            state <= WALK_IDLE;
                        end else begin
                            idx   <= idx + IDX_W'(1);
                            state <= WALK_SCAN;
                        end
                    end
                end
                default: state <= WALK_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/l1_flush_ctrl.sv
module l1_flush_ctrl
    import l1fc_pkg::*;
#(
    parameter int unsigned NUM_LINES = DEF_LINES,
    parameter int unsigned LINE_BITS = DEF_LINE_BITS,
    parameter int unsigned PERIOD_W  = DEF_PERIOD_W,
    parameter bit          ICACHE    = 1'b0,
    localparam int unsigned IDX_W = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush_en,
    input  logic [PERIOD_W-1:0]  period,
    input  logic                 fill_vld,
    input  logic [IDX_W-1:0]     fill_idx,
    input  logic                 store_vld,
    input  logic [IDX_W-1:0]     store_idx,
    output logic [IDX_W-1:0]     line_idx,
    input  logic [LINE_BITS-1:0] line_data,
    output logic                 wb_req,
    output logic [IDX_W-1:0]     wb_idx,
    output logic [LINE_BITS-1:0] wb_data,
    input  logic                 wb_ack,
    output logic                 busy,
    output logic [NUM_LINES-1:0] valid_bits,
    output logic [NUM_LINES-1:0] dirty_bits
);
    logic             trig;
    logic             clr_all;
    logic             clr_one;
    logic [IDX_W-1:0] walk_idx;

    l1fc_timer #(.PERIOD_W(PERIOD_W)) u_timer (
        .clk(clk), .rst(rst), .en(flush_en), .period(period), .trig(trig)
    );

    l1fc_status #(.NUM_LINES(NUM_LINES)) u_status (
        .clk(clk), .rst(rst), .cpu_ok(!busy),
        .fill_vld(fill_vld), .fill_idx(fill_idx),
        .store_vld(store_vld), .store_idx(store_idx),
        .clr_all(clr_all), .clr_one(clr_one), .clr_idx(walk_idx),
        .valid(valid_bits), .dirty(dirty_bits)
    );

    generate
        if (ICACHE) begin : g_icache
            // Read-only cache: nothing to write back, drop every line at once.
            assign clr_all  = trig;
            assign clr_one  = 1'b0;
            assign walk_idx = '0;
            assign busy     = 1'b0;
            assign wb_req   = 1'b0;
            assign wb_idx   = '0;
            assign wb_data  = '0;
        end else begin : g_dcache
            assign clr_all = 1'b0;
            l1fc_walker #(.NUM_LINES(NUM_LINES), .LINE_BITS(LINE_BITS)) u_walker (
                .clk(clk), .rst(rst), .trig(trig),
                .valid(valid_bits), .dirty(dirty_bits),
                .line_data(line_data), .wb_ack(wb_ack),
                .idx(walk_idx), .busy(busy),
                .wb_req(wb_req), .wb_idx(wb_idx), .wb_data(wb_data),
                .clr_one(clr_one)
            );
        end
    endgenerate

    assign line_idx = walk_idx;
endmodule

// File: rtl/l1_flush_ctrl_chk.sv
module l1_flush_ctrl_chk #(
    parameter int unsigned NUM_LINES = 16,
    parameter int unsigned LINE_BITS = 256,
    parameter bit          ICACHE    = 1'b0,
    localparam int unsigned IDX_W = $clog2(NUM_LINES)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 wb_req,
    input logic [IDX_W-1:0]     wb_idx,
    input logic [LINE_BITS-1:0] wb_data,
    input logic                 wb_ack,
    input logic                 busy,
    input logic [NUM_LINES-1:0] valid_bits,
    input logic [NUM_LINES-1:0] dirty_bits
);
    generate
        if (ICACHE) begin : g_ic
            p_ic_no_walk_r2: assert property (@(posedge clk) disable iff (rst)
                !busy && !wb_req);
        end else begin : g_dc
            p_wb_hold_r5: assert property (@(posedge clk) disable iff (rst)
                wb_req && !wb_ack |=> wb_req && $stable(wb_idx) && $stable(wb_data));
            p_wb_target_r4: assert property (@(posedge clk) disable iff (rst)
                wb_req |-> valid_bits[wb_idx] && dirty_bits[wb_idx]);
            p_no_req_idle_r4: assert property (@(posedge clk) disable iff (rst)
                !busy |-> !wb_req);
            p_ack_drops_r4: assert property (@(posedge clk) disable iff (rst)
                wb_req && wb_ack |=> !valid_bits[$past(wb_idx)] && !wb_req);
            p_end_clean_r3: assert property (@(posedge clk) disable iff (rst)
                $fell(busy) |-> (valid_bits == '0) && (dirty_bits == '0));
        end
    endgenerate
endmodule

bind l1_flush_ctrl l1_flush_ctrl_chk #(
    .NUM_LINES(NUM_LINES), .LINE_BITS(LINE_BITS), .ICACHE(ICACHE)
) u_chk (
    .clk(clk), .rst(rst), .wb_req(wb_req), .wb_idx(wb_idx), .wb_data(wb_data),
    .wb_ack(wb_ack), .busy(busy), .valid_bits(valid_bits), .dirty_bits(dirty_bits)
);

// File: tb/l1_flush_ctrl_bench.sv
`timescale 1ns/1ps
module l1_flush_ctrl_bench;
    localparam int NL = 16;
    localparam int LB = 256;
    localparam int PW = 24;
    localparam int IW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // data-cache instance signals
    logic          flush_en = 1'b0;
    logic [PW-1:0] period = '0;
    logic          fill_vld = 1'b0, store_vld = 1'b0;
    logic [IW-1:0] fill_idx = '0, store_idx = '0;
    logic [IW-1:0] line_idx;
    logic [LB-1:0] line_data;
    logic          wb_req, wb_ack = 1'b0, busy;
    logic [IW-1:0] wb_idx;
    logic [LB-1:0] wb_data;
    logic [NL-1:0] valid_bits, dirty_bits;

    // instruction-cache instance signals
    logic          ic_en = 1'b0;
    logic [PW-1:0] ic_period = '0;
    logic          ic_fill_vld = 1'b0;
    logic [IW-1:0] ic_fill_idx = '0;
    logic [IW-1:0] ic_line_idx, ic_wb_idx;
    logic [LB-1:0] ic_wb_data;
    logic          ic_wb_req, ic_busy;
    logic [NL-1:0] ic_valid, ic_dirty;

    function automatic logic [LB-1:0] line_pat(input logic [IW-1:0] i);
        return {8{i, 28'h3C5A96E}} ^ {LB{i[0]}};
    endfunction

    assign line_data = line_pat(line_idx);

    l1_flush_ctrl #(.NUM_LINES(NL), .LINE_BITS(LB), .PERIOD_W(PW), .ICACHE(1'b0)) u_l1_flush_ctrl (
        .clk(clk), .rst(rst), .flush_en(flush_en), .period(period),
        .fill_vld(fill_vld), .fill_idx(fill_idx), .store_vld(store_vld), .store_idx(store_idx),
        .line_idx(line_idx), .line_data(line_data),
        .wb_req(wb_req), .wb_idx(wb_idx), .wb_data(wb_data), .wb_ack(wb_ack),
        .busy(busy), .valid_bits(valid_bits), .dirty_bits(dirty_bits)
    );

    l1_flush_ctrl #(.NUM_LINES(NL), .LINE_BITS(LB), .PERIOD_W(PW), .ICACHE(1'b1)) u_l1_flush_ctrl_ic (
        .clk(clk), .rst(rst), .flush_en(ic_en), .period(ic_period),
        .fill_vld(ic_fill_vld), .fill_idx(ic_fill_idx), .store_vld(1'b0), .store_idx('0),
        .line_idx(ic_line_idx), .line_data('0),
        .wb_req(ic_wb_req), .wb_idx(ic_wb_idx), .wb_data(ic_wb_data), .wb_ack(1'b0),
        .busy(ic_busy), .valid_bits(ic_valid), .dirty_bits(ic_dirty)
    );

    task automatic chk(input string tag, input bit ok, input string act, input string exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %s expected %s", tag, act, exp);
        end
    endtask

    // writeback responder with random latency
    int wb_cnt = 0, wb_dup = 0, wb_bad = 0, hold_err = 0;
    logic [NL-1:0] wb_mask = '0;
    initial begin
        int dly;
        bit seen;
        logic [IW-1:0] h_idx;
        logic [LB-1:0] h_data;
        dly = 0;
        seen = 0;
        forever begin
            @(negedge clk);
            if (wb_ack) begin
                wb_ack = 1'b0;
                seen = 0;
            end else if (wb_req) begin
                if (!seen) begin
                    seen = 1;
                    h_idx = wb_idx;
                    h_data = wb_data;
                end else if (wb_idx !== h_idx || wb_data !== h_data) begin
                    hold_err++;
                end
                if (dly == 0) begin
                    wb_cnt++;
                    if (wb_mask[wb_idx]) wb_dup++;
                    wb_mask[wb_idx] = 1'b1;
                    if (wb_data !== line_pat(wb_idx)) wb_bad++;
                    wb_ack = 1'b1;
                    dly = int'($urandom % 4);
                end else begin
                    dly--;
                end
            end
        end
    end

    // observers for "never" properties
    bit ic_walked = 0, zero_watch = 0, zero_busy = 0;
    initial forever begin
        @(negedge clk);
        if (!rst && (ic_busy || ic_wb_req)) ic_walked = 1;
        if (zero_watch && busy) zero_busy = 1;
    end

    logic [NL-1:0] mv = '0, md = '0;

    task automatic cpu_op(input bit is_store, input int idx);
        fill_vld  = !is_store;
        store_vld = is_store;
        fill_idx  = idx[IW-1:0];
        store_idx = idx[IW-1:0];
        @(negedge clk);
        fill_vld  = 1'b0;
        store_vld = 1'b0;
        if (!is_store) begin
            mv[idx] = 1'b1;
            md[idx] = 1'b0;
        end else if (mv[idx]) begin
            md[idx] = 1'b1;
        end
    endtask

    task automatic wait_quiet();
        do begin
            while (busy) @(negedge clk);
            @(negedge clk);
        end while (busy);
    endtask

    task automatic wait_busy();
        while (!busy) @(negedge clk);
    endtask

    initial begin
        int t1, t2, n;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R3: reset state
        chk("R3 reset valid", valid_bits == '0, $sformatf("%h", valid_bits), "0");
        chk("R3 reset busy", busy == 1'b0, $sformatf("%b", busy), "0");
        chk("R3 reset wb_req", wb_req == 1'b0, $sformatf("%b", wb_req), "0");

        // R9: status updates
        cpu_op(0, 2);
        cpu_op(0, 5);
        cpu_op(1, 5);
        cpu_op(1, 7);
        chk("R9 valid after ops", valid_bits == 16'h0024, $sformatf("%h", valid_bits), "0024");
        chk("R9 dirty after ops", dirty_bits == 16'h0020, $sformatf("%h", dirty_bits), "0020");
        cpu_op(0, 5);
        chk("R9 refill clears dirty", dirty_bits == '0, $sformatf("%h", dirty_bits), "0000");

        // R1 / R6: period and walk length with no dirty lines
        period = 40;
        flush_en = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!busy);
        t1 = cyc;
        chk("R1 first trigger delay", n == 40, $sformatf("%0d", n), "40");
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        chk("R6 walk length", n == NL, $sformatf("%0d", n), $sformatf("%0d", NL));
        wait_busy();
        t2 = cyc;
        chk("R1 trigger interval", (t2 - t1) == 40, $sformatf("%0d", t2 - t1), "40");
        flush_en = 1'b0;
        wait_quiet();

        // R7: trigger during a walk is held
        period = 8;
        flush_en = 1'b1;
        wait_busy();
        while (busy) @(negedge clk);
        chk("R7 gap low", busy == 1'b0, $sformatf("%b", busy), "0");
        @(negedge clk);
        chk("R7 held trigger served", busy == 1'b1, $sformatf("%b", busy), "1");
        flush_en = 1'b0;
        wait_quiet();

        // R1: period zero never triggers
        period = 0;
        flush_en = 1'b1;
        zero_watch = 1;
        repeat (100) @(negedge clk);
        zero_watch = 0;
        flush_en = 1'b0;
        chk("R1 zero period idle", zero_busy == 0, $sformatf("%b", zero_busy), "0");

        // R8: CPU updates refused during a walk
        for (int i = 0; i < NL; i++) cpu_op(0, i);
        period = 3;
        flush_en = 1'b1;
        wait_busy();
        flush_en = 1'b0;
        repeat (3) @(negedge clk);
        fill_vld = 1'b1;
        fill_idx = 0;
        @(negedge clk);
        fill_vld = 1'b0;
        chk("R8 fill ignored while busy", valid_bits[0] == 1'b0, $sformatf("%b", valid_bits[0]), "0");
        wait_quiet();
        chk("R8 all clear after walk", valid_bits == '0, $sformatf("%h", valid_bits), "0000");
        mv = '0;
        md = '0;

        // R4 / R5 / R3: random contents, random ack latency
        for (int r = 0; r < 6; r++) begin
            for (int k = 0; k < 24; k++) cpu_op(($urandom % 3) == 0, int'($urandom % NL));
            if (r == 0) begin
                for (int i = 0; i < NL; i++) cpu_op(0, i);
                for (int i = 0; i < NL; i++) cpu_op(1, i);
            end
            chk($sformatf("R9 model valid round %0d", r), valid_bits == mv,
                $sformatf("%h", valid_bits), $sformatf("%h", mv));
            chk($sformatf("R9 model dirty round %0d", r), dirty_bits == md,
                $sformatf("%h", dirty_bits), $sformatf("%h", md));
            wb_cnt = 0; wb_dup = 0; wb_bad = 0; wb_mask = '0;
            period = PW'(5 + ($urandom % 10));
            flush_en = 1'b1;
            wait_busy();
            flush_en = 1'b0;
            wait_quiet();
            chk($sformatf("R4 writeback set round %0d", r), wb_mask == (md & mv),
                $sformatf("%h", wb_mask), $sformatf("%h", md & mv));
            chk($sformatf("R4 writeback count round %0d", r), wb_cnt == $countones(md & mv) && wb_dup == 0,
                $sformatf("%0d/%0d dup", wb_cnt, wb_dup), $sformatf("%0d/0 dup", $countones(md & mv)));
            chk($sformatf("R4 writeback data round %0d", r), wb_bad == 0, $sformatf("%0d bad", wb_bad), "0 bad");
            chk($sformatf("R3 clean after walk round %0d", r), valid_bits == '0 && dirty_bits == '0,
                $sformatf("%h/%h", valid_bits, dirty_bits), "0000/0000");
            mv = '0;
            md = '0;
        end
        chk("R5 request held until ack", hold_err == 0, $sformatf("%0d", hold_err), "0");

        // R2: instruction-cache variant at a 10K period
        foreach (ic_valid[i]) begin
            if (i == 1 || i == 3 || i == 9) begin
                ic_fill_vld = 1'b1;
                ic_fill_idx = IW'(i);
                @(negedge clk);
            end
        end
        ic_fill_vld = 1'b0;
        @(negedge clk);
        chk("R2 icache filled", ic_valid == 16'h020A, $sformatf("%h", ic_valid), "020a");
        ic_period = 10000;
        ic_en = 1'b1;
        repeat (9999) @(negedge clk);
        chk("R2 icache held before trigger", ic_valid == 16'h020A, $sformatf("%h", ic_valid), "020a");
        @(negedge clk);
        chk("R2 icache cleared on trigger", ic_valid == '0, $sformatf("%h", ic_valid), "0000");
        ic_en = 1'b0;
        chk("R2 icache never walks", ic_walked == 0, $sformatf("%b", ic_walked), "0");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule